// File: doc/BRIEF.md
# Cascadable Dual 8-Bit Timer

This block holds two 8-bit timer channels, a lower one and an upper one. Each channel has its own counter, two compare registers, a control register and a control/status register with three sticky flags. Each channel drives one output pin from its compare-A events. While the channels run apart, each one counts on the shared `tick` input, compares its own count, clears itself and drives its own pin.

When the upper channel's clock-select field holds the join code, the two counters act as one 16-bit counter. The upper counter is the high byte and the lower counter is the low byte. The upper channel then reports 16-bit compare events and the 16-bit overflow. The lower channel keeps reporting low-byte events. Only the upper clear-select field acts, and it clears all sixteen bits. One capture input, with a selectable edge, latches the counter value and flags both channels together.

A small mode state machine follows the upper clock-select field:

- **MODE_SPLIT**: the two channels run apart. The transition **JOIN** moves it to MODE_JOINED once the field reads 100.
- **MODE_JOINED**: the channels form one 16-bit counter. The transition **UNJOIN** moves it back to MODE_SPLIT once the field holds any other code.

The state changes one clock after the control write.

Top module: `dual_timer8`

## Requirements
- R1: After reset, every register of both channels reads 0 and both output pins are low.
- R2: Register map. `bus_addr[3]` picks the channel (1 = upper, 0 = lower) and `bus_addr[2:0]` picks the register: 0 control, 1 control/status, 2 compare A, 3 compare B, 4 counter (writable), 5 capture value (read only); offsets 6 and 7 read 0.
  - Control: bits [2:0] are the clock select (000 stopped, 100 on the upper channel means join, any other code counts once per cycle with `tick` high). Bits [4:3] are the clear select.
  - Control/status: bit 0 is the compare-A flag, bit 1 the compare-B/capture flag and bit 2 the overflow flag. Bits [4:3] are the output select, bits [6:5] the edge select (upper channel's field used) and bit 7 the capture enable (lower channel's bit used).
- R3: A compare event happens on a counting tick taken while the count equals the compare value. In split mode, each channel sets its compare-A flag on its own events. With clear select 01 it returns to 0 instead of counting, so a compare-A value of N gives a period of N+1 ticks.
- R4: While the upper clock select is 100, the counters form one 16-bit counter. The low byte counts on the lower channel's clock select and the high byte advances when the low byte wraps. Writing another code returns the upper channel to counting on its own.
- R5: In joined mode, the upper compare-A flag sets only when all 16 bits equal {upper compare A, lower compare A}.
- R6: In joined mode, the lower compare-A flag sets whenever the low byte equals the lower compare A, whatever the high byte holds.
- R7: A channel's overflow flag sets when its counter wraps from all ones to zero. In joined mode, the upper flag marks the 16'hFFFF to 16'h0000 wrap and the lower flag marks every 8'hFF to 8'h00 wrap of the low byte. A clear on the same tick suppresses the flag.
- R8: Clear select is 00 none, 01 on compare A, 10 on compare B or capture, 11 none. In joined mode only the upper field acts and it clears all 16 bits. The lower field has no effect.
- R9: Output select is 00 keep, 01 drive low, 10 drive high, 11 toggle, applied on the channel's compare-A event. In joined mode, the upper pin uses 16-bit events and the lower pin uses low-byte events.
- R10: With capture enable set, a selected edge on `cap_in` sets bit 1 in both channels in the same cycle and latches the count into both capture registers. Edge select is 00 none, 01 rising, 10 falling, 11 both.
- R11: A flag clears only when 0 is written to it after it was read as 1. Writing 0 without that read leaves it set. A set condition in the same cycle as the clearing write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable pulse shared by both channels |
| cap_in | input | 1 | Capture input, synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flag clearing) |
| bus_addr | input | 4 | Channel select in bit 3, register offset in bits 2:0 |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for the addressed register |
| out_hi | output | 1 | Upper channel compare output pin |
| out_lo | output | 1 | Lower channel compare output pin |

## Verification
The collision that matters most is a flag-clearing write landing in the same cycle as a compare event that sets that flag. The bench arms the compare-A flag with a read and rewinds the counter onto the compare value. It then raises `tick` in the same cycle as the write of 0, and expects the flag still to read 1 afterwards. A second collision is a low-byte match coinciding with a 16-bit clear in joined mode. Here the bench expects the lower pin and lower flag to respond while the 16-bit counter returns to zero.

// File: rtl/dt_pkg.sv
package dt_pkg;
    localparam int unsigned NCH   = 2;
    localparam int unsigned CH_LO = 0;
    localparam int unsigned CH_HI = 1;

    localparam int unsigned NFLAG    = 3;
    localparam int unsigned FLAG_A   = 0;
    localparam int unsigned FLAG_B   = 1;
    localparam int unsigned FLAG_OVF = 2;

    localparam logic [2:0] OFF_CTRL = 3'd0;
    localparam logic [2:0] OFF_CSR  = 3'd1;
    localparam logic [2:0] OFF_CMPA = 3'd2;
    localparam logic [2:0] OFF_CMPB = 3'd3;
    localparam logic [2:0] OFF_CNT  = 3'd4;
    localparam logic [2:0] OFF_CAP  = 3'd5;

    localparam logic [2:0] CLK_STOP = 3'b000;
    localparam logic [2:0] CLK_JOIN = 3'b100;

    typedef enum logic [1:0] {CLR_NONE, CLR_ON_A, CLR_ON_B_CAP, CLR_RSVD} clr_sel_e;
    typedef enum logic [1:0] {OUT_KEEP, OUT_LOW, OUT_HIGH, OUT_TOGGLE} out_sel_e;
    typedef enum logic [1:0] {EDGE_NONE, EDGE_RISE, EDGE_FALL, EDGE_BOTH} edge_sel_e;
    typedef enum logic {MODE_SPLIT, MODE_JOINED} mode_e;

    function automatic logic clear_hit(clr_sel_e sel, logic hit_a, logic hit_b_cap);
        logic r;
        unique case (sel)
            CLR_ON_A:     r = hit_a;
            CLR_ON_B_CAP: r = hit_b_cap;
            default:      r = 1'b0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/dt_mode_fsm.sv
module dt_mode_fsm
    import dt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hi_clk_sel,
    output mode_e      mode
);
    mode_e state_q;
    mode_e state_d;
    logic  join_req;

    assign join_req = (hi_clk_sel == CLK_JOIN);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_SPLIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_SPLIT:  if (join_req)  state_d = MODE_JOINED;
            MODE_JOINED: if (!join_req) state_d = MODE_SPLIT;
            default:     state_d = MODE_SPLIT;
        endcase
    end

    assign mode = state_q;
endmodule

// File: rtl/dt_capture.sv
module dt_capture
    import dt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cap_in,
    input  edge_sel_e edge_sel,
    input  logic      enable,
    output logic      cap_evt
);
    logic prev_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cap_in;
    end

    assign rise = cap_in & ~prev_q;
    assign fall = ~cap_in & prev_q;

    always_comb begin
        cap_evt = 1'b0;
        unique case (edge_sel)
            EDGE_NONE: cap_evt = 1'b0;
            EDGE_RISE: cap_evt = enable & rise;
            EDGE_FALL: cap_evt = enable & fall;
            EDGE_BOTH: cap_evt = enable & (rise | fall);
            default:   cap_evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/dt_channel.sv
module dt_channel
    import dt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             sel,
    input  logic [2:0]       reg_addr,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata,
    input  logic             inc,
    input  logic             clr,
    input  logic             evt_a,
    input  logic             evt_b,
    input  logic             evt_cap,
    input  logic             evt_ovf,
    input  logic [W-1:0]     cap_val,
    output logic [W-1:0]     cnt,
    output logic [W-1:0]     cmp_a,
    output logic [W-1:0]     cmp_b,
    output logic [2:0]       clk_sel,
    output clr_sel_e         clr_sel,
    output out_sel_e         out_sel,
    output edge_sel_e        edge_sel,
    output logic             cap_en,
    output logic [NFLAG-1:0] flags,
    output logic             pin
);
    logic [W-1:0] ctrl_q;
    logic [W-1:0] cfg_q;
    logic [W-1:0] cmpa_q;
    logic [W-1:0] cmpb_q;
    logic [W-1:0] cnt_q;
    logic [W-1:0] cap_q;
    logic         pin_q;
    logic         wr_hit;
    logic         csr_wr;
    logic         csr_rd;
    logic [NFLAG-1:0] set_vec;

    assign wr_hit  = wr_en & sel;
    assign csr_wr  = wr_hit & (reg_addr == OFF_CSR);
    assign csr_rd  = rd_en & sel & (reg_addr == OFF_CSR);
    assign set_vec = {evt_ovf, evt_b | evt_cap, evt_a};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cfg_q  <= '0;
            cmpa_q <= '0;
            cmpb_q <= '0;
        end else if (wr_hit) begin
            if (reg_addr == OFF_CTRL) ctrl_q <= wdata;
            if (reg_addr == OFF_CSR)  cfg_q  <= {wdata[W-1:NFLAG], {NFLAG{1'b0}}};
            if (reg_addr == OFF_CMPA) cmpa_q <= wdata;
            if (reg_addr == OFF_CMPB) cmpb_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                              cnt_q <= '0;
        else if (wr_hit && reg_addr == OFF_CNT)  cnt_q <= wdata;
        else if (clr)                            cnt_q <= '0;
        else if (inc)                            cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       cap_q <= '0;
        else if (evt_cap) cap_q <= cap_val;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        logic f_q;
        logic arm_q;
        logic clr_req;

        assign clr_req = csr_wr & arm_q & ~wdata[i];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                f_q   <= 1'b0;
                arm_q <= 1'b0;
            end else begin
                if (set_vec[i])   f_q <= 1'b1;
                else if (clr_req) f_q <= 1'b0;

                if (clr_req && !set_vec[i]) arm_q <= 1'b0;
                else if (csr_rd && f_q)     arm_q <= 1'b1;
            end
        end

        assign flags[i] = f_q;
    end

    assign clk_sel  = ctrl_q[2:0];
    assign clr_sel  = clr_sel_e'(ctrl_q[4:3]);
    assign out_sel  = out_sel_e'(cfg_q[4:3]);
    assign edge_sel = edge_sel_e'(cfg_q[6:5]);
    assign cap_en   = cfg_q[7];
    assign cnt      = cnt_q;
    assign cmp_a    = cmpa_q;
    assign cmp_b    = cmpb_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else if (evt_a) begin
            unique case (out_sel)
                OUT_KEEP:   pin_q <= pin_q;
                OUT_LOW:    pin_q <= 1'b0;
                OUT_HIGH:   pin_q <= 1'b1;
                OUT_TOGGLE: pin_q <= ~pin_q;
                default:    pin_q <= pin_q;
            endcase
        end
    end

    assign pin = pin_q;

    always_comb begin
        rdata = '0;
        case (reg_addr)
            OFF_CTRL: rdata = ctrl_q;
            OFF_CSR:  rdata = cfg_q | {{(W-NFLAG){1'b0}}, flags};
            OFF_CMPA: rdata = cmpa_q;
            OFF_CMPB: rdata = cmpb_q;
            OFF_CNT:  rdata = cnt_q;
            OFF_CAP:  rdata = cap_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/dual_timer8.sv
module dual_timer8
    import dt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         cap_in,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [3:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    output logic         out_hi,
    output logic         out_lo
);
    localparam int W2 = 2 * W;

    mode_e            mode_q;
    logic             cap_evt;
    logic [W-1:0]     ch_rdata   [NCH];
    logic [W-1:0]     ch_cnt     [NCH];
    logic [W-1:0]     ch_cmp_a   [NCH];
    logic [W-1:0]     ch_cmp_b   [NCH];
    logic [2:0]       ch_clk_sel [NCH];
    clr_sel_e         ch_clr_sel [NCH];
    out_sel_e         ch_out_sel [NCH];
    edge_sel_e        ch_edge    [NCH];
    logic             ch_cap_en  [NCH];
    logic [NFLAG-1:0] ch_flags   [NCH];
    logic [NCH-1:0]   ch_pin;
    logic [NCH-1:0]   ch_inc;
    logic [NCH-1:0]   ch_clr;
    logic [NCH-1:0]   ch_evt_a;
    logic [NCH-1:0]   ch_evt_b;
    logic [NCH-1:0]   ch_evt_ovf;
    logic [NCH-1:0]   run_split;

    logic [W2-1:0]    cnt16;
    logic [W2-1:0]    cmp16_a;
    logic [W2-1:0]    cmp16_b;
    logic             lo_run;
    logic             hit16_a;
    logic             hit16_b;
    logic             clr16;

    dt_mode_fsm u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .hi_clk_sel (ch_clk_sel[CH_HI]),
        .mode       (mode_q)
    );

    dt_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_in   (cap_in),
        .edge_sel (ch_edge[CH_HI]),
        .enable   (ch_cap_en[CH_LO]),
        .cap_evt  (cap_evt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign run_split[g] = tick && (ch_clk_sel[g] != CLK_STOP)
                              && !((g == CH_HI) && (ch_clk_sel[g] == CLK_JOIN));

        dt_channel #(.W(W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bus_wr),
            .rd_en    (bus_rd),
            .sel      (bus_addr[3] == 1'(g)),
            .reg_addr (bus_addr[2:0]),
            .wdata    (bus_wdata),
            .rdata    (ch_rdata[g]),
            .inc      (ch_inc[g]),
            .clr      (ch_clr[g]),
            .evt_a    (ch_evt_a[g]),
            .evt_b    (ch_evt_b[g]),
            .evt_cap  (cap_evt),
            .evt_ovf  (ch_evt_ovf[g]),
            .cap_val  (ch_cnt[g]),
            .cnt      (ch_cnt[g]),
            .cmp_a    (ch_cmp_a[g]),
            .cmp_b    (ch_cmp_b[g]),
            .clk_sel  (ch_clk_sel[g]),
            .clr_sel  (ch_clr_sel[g]),
            .out_sel  (ch_out_sel[g]),
            .edge_sel (ch_edge[g]),
            .cap_en   (ch_cap_en[g]),
            .flags    (ch_flags[g]),
            .pin      (ch_pin[g])
        );
    end

    assign cnt16   = {ch_cnt[CH_HI], ch_cnt[CH_LO]};
    assign cmp16_a = {ch_cmp_a[CH_HI], ch_cmp_a[CH_LO]};
    assign cmp16_b = {ch_cmp_b[CH_HI], ch_cmp_b[CH_LO]};
    assign lo_run  = tick && (ch_clk_sel[CH_LO] != CLK_STOP);
    assign hit16_a = lo_run && (cnt16 == cmp16_a);
    assign hit16_b = lo_run && (cnt16 == cmp16_b);
    assign clr16   = clear_hit(ch_clr_sel[CH_HI], hit16_a, hit16_b | cap_evt);

    always_comb begin
        ch_inc     = '0;
        ch_clr     = '0;
        ch_evt_a   = '0;
        ch_evt_b   = '0;
        ch_evt_ovf = '0;
        unique case (mode_q)
            MODE_SPLIT: begin
                for (int g = 0; g < NCH; g++) begin
                    ch_inc[g]     = run_split[g];
                    ch_evt_a[g]   = run_split[g] && (ch_cnt[g] == ch_cmp_a[g]);
                    ch_evt_b[g]   = run_split[g] && (ch_cnt[g] == ch_cmp_b[g]);
                    ch_clr[g]     = clear_hit(ch_clr_sel[g], ch_evt_a[g],
                                              ch_evt_b[g] | cap_evt);
                    ch_evt_ovf[g] = run_split[g] && (ch_cnt[g] == '1) && !ch_clr[g];
                end
            end
            MODE_JOINED: begin
                ch_inc[CH_LO]     = lo_run;
                ch_inc[CH_HI]     = lo_run && (ch_cnt[CH_LO] == '1);
                ch_clr[CH_LO]     = clr16;
                ch_clr[CH_HI]     = clr16;
                ch_evt_a[CH_LO]   = lo_run && (ch_cnt[CH_LO] == ch_cmp_a[CH_LO]);
                ch_evt_b[CH_LO]   = lo_run && (ch_cnt[CH_LO] == ch_cmp_b[CH_LO]);
                ch_evt_a[CH_HI]   = hit16_a;
                ch_evt_b[CH_HI]   = hit16_b;
                ch_evt_ovf[CH_LO] = lo_run && (ch_cnt[CH_LO] == '1) && !clr16;
                ch_evt_ovf[CH_HI] = lo_run && (cnt16 == '1) && !clr16;
            end
            default: ;
        endcase
    end

    assign bus_rdata = ch_rdata[bus_addr[3]];
    assign out_hi    = ch_pin[CH_HI];
    assign out_lo    = ch_pin[CH_LO];
endmodule

// File: rtl/dt_checker.sv
module dt_checker
    import dt_pkg::*;
#(
    parameter int W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             joined,
    input logic             bus_wr,
    input logic [W-1:0]     cnt_lo,
    input logic [W-1:0]     cnt_hi,
    input logic             cap_evt,
    input logic [NFLAG-1:0] flags_lo,
    input logic [NFLAG-1:0] flags_hi,
    input logic             evt_a_lo,
    input logic             evt_a_hi,
    input logic             ovf_hi,
    input logic [1:0]       osel_lo,
    input logic             out_lo
);
    assert_full_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (joined && evt_a_hi) |-> evt_a_lo);

    assert_joint_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (joined && !bus_wr && cnt_lo != '1 && cnt_lo != '0)
        |=> (cnt_lo != '0 || cnt_hi == '0));

    assert_wrap16_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (joined && ovf_hi && !bus_wr) |=> (cnt_hi == '0 && cnt_lo == '0));

    assert_pin_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_a_lo && osel_lo == 2'b10) |=> out_lo);

    assert_capture_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (flags_lo[FLAG_B] && flags_hi[FLAG_B]));

    assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags_lo[FLAG_A]) |-> $past(bus_wr));
endmodule

bind dual_timer8 dt_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .joined   (mode_q == MODE_JOINED),
    .bus_wr   (bus_wr),
    .cnt_lo   (ch_cnt[CH_LO]),
    .cnt_hi   (ch_cnt[CH_HI]),
    .cap_evt  (cap_evt),
    .flags_lo (ch_flags[CH_LO]),
    .flags_hi (ch_flags[CH_HI]),
    .evt_a_lo (ch_evt_a[CH_LO]),
    .evt_a_hi (ch_evt_a[CH_HI]),
    .ovf_hi   (ch_evt_ovf[CH_HI]),
    .osel_lo  (ch_out_sel[CH_LO]),
    .out_lo   (out_lo)
);

// File: tb/test_dual_timer8.sv
`timescale 1ns/1ps
module test_dual_timer8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cap_in = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       out_hi;
    logic       out_lo;

    int checks = 0;
    int failures = 0;

    localparam int LO = 0;
    localparam int HI = 1;

    always #2.5 clk = ~clk;

    dual_timer8 #(.W(8)) i_dual_timer8 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cap_in(cap_in),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .out_hi(out_hi), .out_lo(out_lo)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int off, input logic [7:0] d);
        @(negedge clk);
        bus_addr = {1'(ch), 3'(off)}; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int ch, input int off, output logic [7:0] d);
        @(negedge clk);
        bus_addr = {1'(ch), 3'(off)}; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic clr_flags(input int ch, input logic [7:0] cfg);
        logic [7:0] d;
        rd(ch, 1, d);
        wr(ch, 1, cfg & 8'hF8);
    endtask

    task automatic set16(input logic [15:0] v);
        wr(HI, 4, v[15:8]);
        wr(LO, 4, v[7:0]);
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] h, l;
        rd(HI, 4, h);
        rd(LO, 4, l);
        v = {h, l};
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [7:0]  d, d2;
        logic [15:0] v;
        bit          expc;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2: reset state over the whole map
        for (int ch = 0; ch < 2; ch++)
            for (int off = 0; off < 8; off++) begin
                rd(ch, off, d);
                chk("R1 reset register", d, 0);
            end
        chk("R1 reset out_hi", out_hi, 0);
        chk("R1 reset out_lo", out_lo, 0);

        // R2: compare register readback
        wr(LO, 3, 8'hAA); wr(HI, 3, 8'hAA);
        rd(LO, 3, d); chk("R2 compare B readback", d, 8'hAA);

        // R3: split-mode period sweep, lower channel, clear on A
        for (int n = 0; n < 16; n++) begin
            wr(LO, 0, 8'h00);
            wr(LO, 2, 8'(n));
            wr(LO, 4, 8'h00);
            clr_flags(LO, 8'h00);
            wr(LO, 0, 8'h09);
            ticks(n);
            rd(LO, 4, d); chk("R3 count before match", d, n);
            rd(LO, 1, d); chk("R3 flag A before match", d[0], 0);
            ticks(1);
            rd(LO, 4, d); chk("R3 clear after N+1 ticks", d, 0);
            rd(LO, 1, d); chk("R3 flag A at match", d[0], 1);
        end
        wr(LO, 0, 8'h00);
        clr_flags(LO, 8'h00);

        // R3: upper channel on its own, no clear
        wr(HI, 2, 8'h03); wr(HI, 4, 8'h00); clr_flags(HI, 8'h00);
        wr(HI, 0, 8'h01);
        ticks(4);
        rd(HI, 4, d); chk("R3 upper split count", d, 4);
        rd(HI, 1, d); chk("R3 upper split flag A", d[0], 1);
        rd(LO, 4, d); chk("R3 lower idle while stopped", d, 0);
        wr(HI, 0, 8'h00); clr_flags(HI, 8'h00);

        // R7 split overflow + R11 write without read
        wr(LO, 2, 8'h10); wr(LO, 4, 8'hFF); wr(LO, 0, 8'h01);
        ticks(1);
        wr(LO, 1, 8'h00);
        rd(LO, 1, d); chk("R11 unread flag survives write", d[2], 1);
        chk("R7 split overflow flag", d[2], 1);
        rd(LO, 4, d); chk("R7 split wrap to zero", d, 0);
        wr(LO, 1, 8'h00);
        rd(LO, 1, d); chk("R11 read then write clears", d[2], 0);

        // R11: set wins over clearing write
        wr(LO, 2, 8'h05); wr(LO, 4, 8'h05);
        ticks(1);
        rd(LO, 1, d); chk("R11 flag A set", d[0], 1);
        wr(LO, 4, 8'h05);
        @(negedge clk);
        bus_addr = {1'b0, 3'd1}; bus_wdata = 8'h00; bus_wr = 1'b1; tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick = 1'b0;
        rd(LO, 1, d); chk("R11 set wins over clear", d[0], 1);
        rd(LO, 4, d); chk("R11 count advanced", d, 6);
        wr(LO, 1, 8'h00);
        rd(LO, 1, d); chk("R11 later clear", d[0], 0);
        wr(LO, 0, 8'h00);

        // R4-R7: joined mode
        wr(HI, 2, 8'h01); wr(LO, 2, 8'h02);
        set16(16'h00FE);
        clr_flags(LO, 8'h00); clr_flags(HI, 8'h00);
        wr(HI, 0, 8'h04); wr(LO, 0, 8'h01);
        ticks(4);
        rd16(v); chk("R4 16-bit carry into high byte", v, 16'h0102);
        rd(LO, 1, d); rd(HI, 1, d2);
        chk("R7 low byte wrap flag", d[2], 1);
        chk("R7 no 16-bit wrap yet", d2[2], 0);
        chk("R5 no full match yet", d2[0], 0);
        ticks(1);
        rd(LO, 1, d); rd(HI, 1, d2);
        chk("R5 upper flag on 16-bit match", d2[0], 1);
        chk("R6 lower flag on low match", d[0], 1);
        clr_flags(LO, 8'h00); clr_flags(HI, 8'h00);
        set16(16'h0500);
        ticks(3);
        rd(LO, 1, d); rd(HI, 1, d2);
        chk("R6 low match with other high byte", d[0], 1);
        chk("R5 no upper flag on partial match", d2[0], 0);
        clr_flags(LO, 8'h00); clr_flags(HI, 8'h00);
        set16(16'hFFFE);
        ticks(1);
        rd(HI, 1, d2); chk("R7 no wrap at FFFE", d2[2], 0);
        ticks(1);
        rd(LO, 1, d); rd(HI, 1, d2);
        chk("R7 16-bit wrap flag", d2[2], 1);
        chk("R7 low wrap flag on 16-bit wrap", d[2], 1);
        rd16(v); chk("R7 counter at zero", v, 0);

        // R8: clearing follows upper field only
        clr_flags(LO, 8'h00); clr_flags(HI, 8'h00);
        set16(16'h0000);
        wr(HI, 0, 8'h0C); wr(LO, 0, 8'h09);
        ticks(3);
        rd16(v); chk("R8 lower clear field ignored", v, 16'h0003);
        ticks(255);
        rd16(v); chk("R8 reaches compare", v, 16'h0102);
        ticks(1);
        rd16(v); chk("R8 16-bit clear", v, 0);
        rd(HI, 1, d2); chk("R8 upper flag A at clear", d2[0], 1);

        // R9: output pins
        wr(LO, 2, 8'h03);
        clr_flags(HI, 8'h18); clr_flags(LO, 8'h10);
        set16(16'h0000);
        ticks(4);
        chk("R9 lower pin high on low match", out_lo, 1);
        chk("R9 upper pin waits for 16-bit match", out_hi, 0);
        ticks(256);
        chk("R9 upper pin toggles", out_hi, 1);
        rd16(v); chk("R9 cleared at period end", v, 0);
        ticks(260);
        chk("R9 upper pin toggles back", out_hi, 0);
        wr(LO, 1, 8'h08);
        ticks(4);
        chk("R9 lower pin driven low", out_lo, 0);

        // R10: capture edge sweep, counter stopped
        wr(LO, 0, 8'h00); wr(HI, 0, 8'h04);
        for (int es = 0; es < 4; es++)
            for (int dir = 0; dir < 2; dir++) begin
                wr(HI, 4, 8'h02);
                wr(LO, 4, 8'(8'h30 + es * 2 + dir));
                @(negedge clk); cap_in = 1'(dir);
                repeat (2) @(negedge clk);
                clr_flags(HI, 8'(es << 5)); clr_flags(LO, 8'h80);
                @(negedge clk); cap_in = ~cap_in;
                @(negedge clk);
                expc = (es == 3) || (es == 1 && dir == 0) || (es == 2 && dir == 1);
                rd(LO, 1, d); rd(HI, 1, d2);
                chk("R10 lower capture flag", d[1], int'(expc));
                chk("R10 upper capture flag", d2[1], int'(expc));
                if (expc) begin
                    rd(LO, 5, d); chk("R10 low byte captured", d, 8'h30 + es * 2 + dir);
                    rd(HI, 5, d); chk("R10 high byte captured", d, 8'h02);
                end
            end
        clr_flags(HI, 8'h60); clr_flags(LO, 8'h00);
        @(negedge clk); cap_in = ~cap_in;
        @(negedge clk);
        rd(LO, 1, d); chk("R10 capture disabled", d[1], 0);

        // R8: clear on capture
        @(negedge clk); cap_in = 1'b0;
        repeat (2) @(negedge clk);
        wr(HI, 0, 8'h14);
        set16(16'h0234);
        clr_flags(HI, 8'h20); clr_flags(LO, 8'h80);
        @(negedge clk); cap_in = 1'b1;
        @(negedge clk);
        rd16(v); chk("R8 capture clears 16 bits", v, 0);
        rd(LO, 5, d); chk("R10 value before clear", d, 8'h34);

        // R4: leaving joined mode
        wr(LO, 1, 8'h00);
        wr(HI, 0, 8'h01); wr(LO, 0, 8'h00);
        set16(16'h0000);
        ticks(3);
        rd(HI, 4, d); chk("R4 upper counts alone after unjoin", d, 3);
        rd(LO, 4, d); chk("R4 lower stays stopped", d, 0);

        summary();
        $finish;
    end
endmodule